// File: doc/BRIEF.md
# DMA Channel Peripheral Handshake Controller

This block is the handshake logic for a single DMA channel that moves operands between an external peripheral and memory. It watches an active-low request pin from the peripheral and answers each granted transfer with an active-low acknowledge. It holds the end of a single-address transfer until the peripheral's active-low ready pin is sampled asserted. An active-low open-drain done line marks the last operand, and either side may pull it. An active-low transfer-complete strobe pulses for one clock after every bus cycle, whether the channel or the CPU ran it. The bus cycle itself is left to a separate bus engine: this block raises `bus_go_o` for the cycle and waits for `bus_rdy_i`.

There are three operating modes. In external burst mode the synchronized request level keeps transfers running back to back. In external cycle-steal mode each falling edge of the request pin is latched as one pending transfer. In internal mode no pin is needed, and a programmable count of idle clocks between transfers limits how much of the bus the channel takes. A run begins when `mode_i` leaves the off code. It ends after the programmed number of operands, or earlier if the done line is seen low during a transfer. The channel then stays halted until `mode_i` returns to off.

The state machine has five states. IDLE (off) goes to ARM when `mode_i` is non-zero, and the operand count is loaded on that move. ARM (waiting for a request) goes to XFER once the mode's request condition holds. XFER (bus cycle under way) has three exits when the cycle finishes: to HALT on the last operand or on done, to GAP in internal mode when the idle count is non-zero, and to ARM otherwise. GAP (throttle idle) goes to ARM after the programmed number of clocks. HALT (run over) goes to IDLE when `mode_i` is off.

Top module: `dma_hs_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `dack_n_o` and `dtc_n_o` are high and `bus_go_o` and `done_drive_o` are low.
- R2: `mode_i` encodes 0 as off, 1 as external burst, 2 as external cycle-steal and 3 as internal. In burst mode, while `dreq_n_i` stays low, transfers follow one another without further edges on the pin.
- R3: In cycle-steal mode each falling edge of `dreq_n_i` yields exactly one transfer, however long the pin then stays low.
- R4: `dack_n_o` is low during every transfer in the two external modes and stays high during transfers in internal mode.
- R5: A transfer does not finish while `rdy_n_i` is high or `bus_rdy_i` is low. `bus_go_o` stays high and no strobe is produced.
- R6: `dtc_n_o` is low for exactly the one clock after each finished transfer and the one clock after each clock in which `cpu_end_i` is high.
- R7: If `done_n_i` is low during a transfer, the run ends when that transfer finishes. No further transfer starts until `mode_i` has been set to off and then to a run mode again.
- R8: `done_drive_o` (pull the done line low) is high only during the last operand's transfer in an external mode. It is never high in internal mode.
- R9: In internal mode `bus_go_o` is low for exactly `idle_gap_i`+1 clocks between successive transfers.
- R10: A run ends after `op_count_i` transfers, and a count of 0 counts as 1. Afterwards the channel makes no transfer until `mode_i` goes off and then back to a run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Channel mode: 0 off, 1 burst, 2 cycle-steal, 3 internal |
| idle_gap_i | input | GAP_W | Idle clocks inserted between internal-mode transfers |
| op_count_i | input | CNT_W | Operands in a run, loaded when the run starts |
| dreq_n_i | input | 1 | Peripheral request, active low, asynchronous |
| rdy_n_i | input | 1 | Peripheral ready, active low |
| done_n_i | input | 1 | Level of the shared done line, active low |
| bus_rdy_i | input | 1 | Bus engine reports the data phase complete |
| cpu_end_i | input | 1 | A CPU bus cycle ends in this clock |
| dack_n_o | output | 1 | Acknowledge to the peripheral, active low |
| done_drive_o | output | 1 | Pull the done line low (open-drain enable) |
| bus_go_o | output | 1 | Bus cycle requested and in progress |
| dtc_n_o | output | 1 | Transfer-complete strobe, active low, one clock |

## Verification
The hardest case to reach is a peripheral pulling the done line in the middle of a transfer, because a normal transfer lasts a single clock. The stimulus first holds `rdy_n_i` high so that the transfer stays in progress. It then pulls the done line while `bus_go_o` is seen high, and only after that releases ready. The cycle-steal case is just as awkward: the request pin is held low for many clocks after each edge, which shows that a held level produces no second transfer.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_BURST    = 2'd1,
        MODE_STEAL    = 2'd2,
        MODE_INTERNAL = 2'd3
    } chan_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_XFER,
        ST_GAP,
        ST_HALT
    } hs_state_e;

endpackage

// File: rtl/dma_hs_reqsync.sv
module dma_hs_reqsync #(
    parameter int SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_n_i,
    input  logic grant_i,
    input  logic clear_i,
    output logic req_level_o,
    output logic req_pend_o
);
    localparam int SH_W = SYNC_LEN + 1;

    logic [SH_W-1:0] shift_q;
    logic            fall_seen;
    logic            pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SH_W-2:0], ~dreq_n_i};
        end
    end

    assign req_level_o = shift_q[SYNC_LEN-1];
    assign fall_seen   = shift_q[SYNC_LEN-1] & ~shift_q[SYNC_LEN];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clear_i) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~grant_i) | fall_seen;
        end
    end

    assign req_pend_o = pend_q;

endmodule

// File: rtl/dma_hs_gap.sv
module dma_hs_gap #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [GAP_W-1:0] load_val_i,
    output logic             last_o
);
    logic [GAP_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q <= GAP_W'(1));

endmodule

// File: rtl/dma_hs_opcnt.sv
module dma_hs_opcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             step_i,
    output logic             last_o
);
    logic [CNT_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_i) begin
            rem_q <= load_val_i;
        end else if (step_i && rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign last_o = (rem_q <= CNT_W'(1));

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
    import dma_hs_pkg::*;
#(
    parameter int GAP_W    = 8,
    parameter int CNT_W    = 16,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [GAP_W-1:0] idle_gap_i,
    input  logic [CNT_W-1:0] op_count_i,
    input  logic             dreq_n_i,
    input  logic             rdy_n_i,
    input  logic             done_n_i,
    input  logic             bus_rdy_i,
    input  logic             cpu_end_i,
    output logic             dack_n_o,
    output logic             done_drive_o,
    output logic             bus_go_o,
    output logic             dtc_n_o
);
    hs_state_e  state_q, state_d;
    chan_mode_e mode_q;
    logic       done_seen_q;
    logic       dtc_q;

    logic req_level, req_pend, req_ok;
    logic gap_last, op_last;
    logic finish, stop_run, ext_mode, run_start;

    assign ext_mode  = (mode_q == MODE_BURST) || (mode_q == MODE_STEAL);
    assign finish    = (state_q == ST_XFER) && bus_rdy_i && !rdy_n_i;
    assign stop_run  = op_last || done_seen_q || !done_n_i;
    assign run_start = (state_q == ST_IDLE) && (mode_i != MODE_OFF);

    always_comb begin
        unique case (mode_q)
            MODE_BURST:    req_ok = req_level;
            MODE_STEAL:    req_ok = req_pend;
            MODE_INTERNAL: req_ok = 1'b1;
            default:       req_ok = 1'b0;
        endcase
    end

    dma_hs_reqsync #(.SYNC_LEN(SYNC_LEN)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .dreq_n_i    (dreq_n_i),
        .grant_i     ((state_q == ST_ARM) && req_ok),
        .clear_i     (state_q == ST_IDLE),
        .req_level_o (req_level),
        .req_pend_o  (req_pend)
    );

    dma_hs_gap #(.GAP_W(GAP_W)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (finish),
        .load_val_i (idle_gap_i),
        .last_o     (gap_last)
    );

    dma_hs_opcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (run_start),
        .load_val_i (op_count_i),
        .step_i     (finish),
        .last_o     (op_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (mode_i != MODE_OFF) state_d = ST_ARM;
            ST_ARM:  if (req_ok) state_d = ST_XFER;
            ST_XFER: begin
                if (finish) begin
                    if (stop_run)
                        state_d = ST_HALT;
                    else if (mode_q == MODE_INTERNAL && idle_gap_i != '0)
                        state_d = ST_GAP;
                    else
                        state_d = ST_ARM;
                end
            end
            ST_GAP:  if (gap_last) state_d = ST_ARM;
            ST_HALT: if (mode_i == MODE_OFF) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_OFF;
            done_seen_q <= 1'b0;
            dtc_q       <= 1'b0;
        end else begin
            state_q     <= state_d;
            if (state_q == ST_IDLE) mode_q <= chan_mode_e'(mode_i);
            done_seen_q <= (state_q == ST_XFER) && !finish && (done_seen_q || !done_n_i);
            dtc_q       <= finish || cpu_end_i;
        end
    end

    // outputs
    always_comb begin
        bus_go_o     = (state_q == ST_XFER);
        dack_n_o     = !((state_q == ST_XFER) && ext_mode);
        done_drive_o = (state_q == ST_XFER) && ext_mode && op_last;
        dtc_n_o      = !dtc_q;
    end

endmodule

// File: rtl/dma_hs_ctrl_chk.sv
module dma_hs_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       rdy_n_i,
    input logic       done_n_i,
    input logic       bus_rdy_i,
    input logic       dack_n_o,
    input logic       done_drive_o,
    input logic       bus_go_o,
    input logic       dtc_n_o
);
    logic fin_now;
    logic halted_q;

    assign fin_now = bus_go_o && bus_rdy_i && !rdy_n_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 halted_q <= 1'b0;
        else if (mode_i == 2'd0)    halted_q <= 1'b0;
        else if (fin_now && !done_n_i) halted_q <= 1'b1;
    end

    p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_go_o && rdy_n_i |=> bus_go_o);

    p_bus_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_go_o && !bus_rdy_i |=> bus_go_o && dtc_n_o);

    p_strobe_after_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_now |=> !dtc_n_o);

    p_drive_in_ext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_drive_o |-> !dack_n_o && bus_go_o);

    p_stop_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted_q |-> !bus_go_o);

endmodule

bind dma_hs_ctrl dma_hs_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .rdy_n_i      (rdy_n_i),
    .done_n_i     (done_n_i),
    .bus_rdy_i    (bus_rdy_i),
    .dack_n_o     (dack_n_o),
    .done_drive_o (done_drive_o),
    .bus_go_o     (bus_go_o),
    .dtc_n_o      (dtc_n_o)
);

// File: tb/dma_hs_ctrl_test.sv
module dma_hs_ctrl_test;
    localparam int GAP_W = 8;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode_i = 2'd0;
    logic [GAP_W-1:0] idle_gap_i = '0;
    logic [CNT_W-1:0] op_count_i = '0;
    logic             dreq_n_i = 1'b1;
    logic             rdy_n_i = 1'b0;
    logic             bus_rdy_i = 1'b1;
    logic             cpu_end_i = 1'b0;
    logic             periph_done = 1'b0;
    logic             done_n_i;
    logic             dack_n_o, done_drive_o, bus_go_o, dtc_n_o;

    int checks = 0;
    int failures = 0;
    logic [1:0] exp_q[$];   // {dack_n expected, done_drive expected}

    always #10 clk = ~clk;

    assign done_n_i = ~(done_drive_o | periph_done);

    dma_hs_ctrl #(.GAP_W(GAP_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .idle_gap_i(idle_gap_i),
        .op_count_i(op_count_i), .dreq_n_i(dreq_n_i), .rdy_n_i(rdy_n_i),
        .done_n_i(done_n_i), .bus_rdy_i(bus_rdy_i), .cpu_end_i(cpu_end_i),
        .dack_n_o(dack_n_o), .done_drive_o(done_drive_o), .bus_go_o(bus_go_o),
        .dtc_n_o(dtc_n_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #2;
        end
    endtask

    task automatic wait_go(input string req);
        int n = 0;
        while (!bus_go_o && n < 60) begin
            tick(1);
            n++;
        end
        check(bus_go_o == 1'b1, req, bus_go_o, 1);
    endtask

    task automatic end_run;
        mode_i = 2'd0;
        dreq_n_i = 1'b1;
        rdy_n_i = 1'b0;
        periph_done = 1'b0;
        tick(4);
    endtask

    // monitor / scoreboard
    logic fin_prev = 1'b0;
    logic cpu_prev = 1'b0;
    always @(negedge clk) begin
        #4;
        if (rst_n) begin
            if (fin_prev || cpu_prev)
                check(dtc_n_o == 1'b0, "R6 strobe", dtc_n_o, 0);
            else if (dtc_n_o == 1'b0)
                check(1'b0, "R6 stray strobe", dtc_n_o, 1);
            if (bus_go_o && bus_rdy_i && !rdy_n_i) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R10 unexpected transfer", 1, 0);
                end else begin
                    logic [1:0] e;
                    e = exp_q.pop_front();
                    check(dack_n_o == e[1], "R4 dack", dack_n_o, e[1]);
                    check(done_drive_o == e[0], "R8 done drive", done_drive_o, e[0]);
                end
            end
            fin_prev = bus_go_o && bus_rdy_i && !rdy_n_i;
            cpu_prev = cpu_end_i;
        end
    end

    initial begin
        #4_000_000;
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int low_cnt;
        // R1 reset
        tick(3);
        check(dack_n_o && dtc_n_o && !bus_go_o && !done_drive_o, "R1 in reset", bus_go_o, 0);
        rst_n = 1'b1;
        tick(2);
        check(dack_n_o && dtc_n_o && !bus_go_o && !done_drive_o, "R1 after reset", bus_go_o, 0);

        // R6 CPU cycle strobe
        cpu_end_i = 1'b1; tick(1); cpu_end_i = 1'b0; tick(3);

        // R2 burst, four operands, last drives done (R8, R10)
        for (int i = 0; i < 4; i++) exp_q.push_back({1'b0, (i == 3)});
        op_count_i = 16'd4; mode_i = 2'd1; dreq_n_i = 1'b0;
        tick(40);
        check(exp_q.size() == 0, "R2 burst count", exp_q.size(), 0);
        check(bus_go_o == 1'b0, "R10 halted", bus_go_o, 0);
        end_run();

        // R10 count 0 treated as 1
        exp_q.push_back(2'b01);
        op_count_i = 16'd0; mode_i = 2'd1; dreq_n_i = 1'b0;
        tick(30);
        check(exp_q.size() == 0, "R10 zero count", exp_q.size(), 0);
        end_run();

        // R3 cycle steal: one transfer per falling edge
        op_count_i = 16'd3; mode_i = 2'd2;
        tick(3);
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back({1'b0, (i == 2)});
            dreq_n_i = 1'b0; tick(15);
            dreq_n_i = 1'b1; tick(5);
            check(exp_q.size() == 0, "R3 one per edge", exp_q.size(), 0);
        end
        dreq_n_i = 1'b0; tick(15);   // halted: edge ignored (R10)
        check(bus_go_o == 1'b0, "R10 edge after run", bus_go_o, 0);
        end_run();

        // R9 internal mode with idle gap 4, dack stays high (R4, R8)
        for (int i = 0; i < 3; i++) exp_q.push_back(2'b10);
        op_count_i = 16'd3; idle_gap_i = 8'd4; mode_i = 2'd3;
        wait_go("R9 start");
        while (bus_go_o) tick(1);
        low_cnt = 0;
        while (!bus_go_o && low_cnt < 40) begin tick(1); low_cnt++; end
        check(low_cnt == 5, "R9 idle gap", low_cnt, 5);
        tick(20);
        check(exp_q.size() == 0, "R9 internal count", exp_q.size(), 0);
        end_run();

        // R9 zero gap gives one idle clock
        for (int i = 0; i < 2; i++) exp_q.push_back(2'b10);
        op_count_i = 16'd2; idle_gap_i = 8'd0; mode_i = 2'd3;
        wait_go("R9 start zero gap");
        while (bus_go_o) tick(1);
        low_cnt = 0;
        while (!bus_go_o && low_cnt < 40) begin tick(1); low_cnt++; end
        check(low_cnt == 1, "R9 zero gap", low_cnt, 1);
        tick(5);
        end_run();

        // R5 ready stall
        op_count_i = 16'd2; mode_i = 2'd1; rdy_n_i = 1'b1; dreq_n_i = 1'b0;
        wait_go("R5 start");
        tick(6);
        check(bus_go_o == 1'b1 && dtc_n_o == 1'b1, "R5 held by ready", bus_go_o, 1);
        rdy_n_i = 1'b0; bus_rdy_i = 1'b0;
        tick(4);
        check(bus_go_o == 1'b1 && dtc_n_o == 1'b1, "R5 held by bus", bus_go_o, 1);
        exp_q.push_back(2'b00);
        exp_q.push_back(2'b01);
        bus_rdy_i = 1'b1;
        tick(20);
        check(exp_q.size() == 0, "R5 completes", exp_q.size(), 0);
        end_run();

        // R7 peripheral asserts done mid-transfer
        op_count_i = 16'd8; mode_i = 2'd1; rdy_n_i = 1'b1; dreq_n_i = 1'b0;
        wait_go("R7 start");
        periph_done = 1'b1; tick(1);
        periph_done = 1'b0;
        exp_q.push_back(2'b00);
        rdy_n_i = 1'b0;
        tick(25);
        check(exp_q.size() == 0, "R7 last transfer", exp_q.size(), 0);
        check(bus_go_o == 1'b0, "R7 stopped", bus_go_o, 0);
        end_run();

        // R7 rearm after off
        exp_q.push_back(2'b01);
        op_count_i = 16'd1; mode_i = 2'd1; dreq_n_i = 1'b0;
        tick(20);
        check(exp_q.size() == 0, "R7 rearm", exp_q.size(), 0);
        end_run();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule